// File: doc/BRIEF.md
# Per-Area Read Wait-State Generator

This block sets the read-cycle length for a bus state controller. When an access starts, the block is told three things: which of eight address areas the access targets, what kind of space lies behind that area, and how many long-wait cycles are set up for it. From these it picks a fixed number of wait cycles. It also decides whether the active-low external `wait_n` line may stretch the access. It then counts the cycles and gives a one-cycle `ready` pulse when the read completes.

A 16-bit configuration word holds the timing controls. The upper byte has one read-wait bit per area: bit 8+n belongs to area n. Bit 1 is a write-wait bit for area 1 when area 1 is DRAM. Every other bit is fixed. Address decoding, RAS/CAS sequencing, write timing and the data path sit outside this block.

Cycle counting works as follows. An access is accepted on the rising edge where `rd_req` is high and `busy` is low. The accepting edge ends cycle 1. An access of T cycles raises `ready` after the edge that ends cycle T, and `ready` stays high for exactly one cycle. When `wait_n` is honoured, it is first sampled on the edge that ends the last fixed wait cycle. Each low sample adds one cycle. The access ends on the first edge where `wait_n` is sampled high.

Top module: `rd_wait_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'hFFFF, and `ready` and `busy` are low.
- R2: An external-space read to area 1, 3, 4, 5 or 7 whose read-wait bit is 0 takes 1 cycle, and `wait_n` has no effect on it.
- R3: An external-space read to area 1, 3, 4, 5 or 7 whose read-wait bit is 1 takes 3 cycles (1 plus 2 waits). Each low sample of `wait_n`, starting at the end of cycle 3, adds one cycle.
- R4: An external-space read to area 0, 2 or 6 whose read-wait bit is 0 takes 1 + `long_wait` cycles, and `wait_n` is not sampled.
- R5: An external-space read to area 0, 2 or 6 whose read-wait bit is 1 takes 1 + `long_wait` cycles, then is stretched by each low sample of `wait_n`. Sampling starts at the end of the last of those cycles.
- R6: For a DRAM-space read (`rd_space` = 1), the area's read-wait bit picks the column cycle. Bit 0 gives 1 cycle and `wait_n` is ignored. Bit 1 gives 3 cycles plus the `wait_n` stretch.
- R7: A multiplexed-I/O read (`rd_space` = 2) takes 5 cycles plus the `wait_n` stretch, whatever the read-wait bits hold.
- R8: An on-chip memory read (`rd_space` = 3) takes 1 cycle. An on-chip peripheral read (`rd_space` = 4) takes 3 cycles. `wait_n` has no effect on either.
- R9: Bit 1 resets to 1. A write of 0 to bit 1 takes effect only while `area1_dram` is high; otherwise the bit keeps its value.
- R10: Bits 7..2 and bit 0 always read 1, and writes to them are ignored. Bits 15..8 take the written value.
- R11: `rd_req` while `busy` is high is ignored. The running access finishes with a single `ready` pulse, and no second access follows from the ignored request.
- R12: `long_wait` has no effect outside external space on areas 0, 2 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| area1_dram | input | 1 | High when area 1 is set up as DRAM; unlocks writing 0 to bit 1 |
| rd_req | input | 1 | Read access start strobe |
| rd_area | input | 3 | Area number of the access (0..7) |
| rd_space | input | 3 | Space type: 0 external, 1 DRAM, 2 multiplexed I/O, 3 on-chip memory, 4 on-chip peripheral |
| long_wait | input | 2 | Long-wait cycles (0..3) for areas 0, 2 and 6 |
| wait_n | input | 1 | External wait request, active low |
| busy | output | 1 | An access is in progress beyond its first cycle |
| ready | output | 1 | One-cycle pulse after the final cycle of an access |

## Verification
Each space type is run with `wait_n` held low through the whole access and with `wait_n` low for a counted number of sampling edges. Comparing the two cases separates the paths that honour the wait line from those that must ignore it. Areas from both the short group and the long-wait group are run with their read-wait bit at 0 and at 1. Every `long_wait` value from 0 to 3 appears, which shows the long wait counts only where it belongs and that the first sampling edge is placed correctly. Configuration writes are made with `area1_dram` low and high to separate the guarded bit from the free bits and from the fixed bits. A request raised mid-access shows that a busy block drops new requests.

// File: rtl/rwg_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the read wait-state generator.
// Assumes at most 7 fixed wait cycles per access (CNT_W bits).
package rwg_pkg;
    localparam int CNT_W = 3;

    typedef enum logic [2:0] {
        SPC_EXT          = 3'd0,
        SPC_DRAM         = 3'd1,
        SPC_MUXIO        = 3'd2,
        SPC_ONCHIP_MEM   = 3'd3,
        SPC_ONCHIP_PERIPH = 3'd4
    } space_e;

    typedef struct packed {
        logic [CNT_W-1:0] waits;   // fixed wait cycles after cycle 1
        logic             sample;  // wait_n honoured at end of fixed part
    } timing_t;
endpackage

// File: rtl/rwg_ctrl_reg.sv
`timescale 1ns/1ps
// Module: configuration word holder.
// Stores one read-wait bit per area in the top AREAS bits and a guarded
// write-wait bit; every other bit reads back as 1 and ignores writes.
// Assumes REG_W > AREAS + 1 so the fields do not overlap.
module rwg_ctrl_reg #(
    parameter int AREAS = 8,
    parameter int REG_W = 16,
    parameter int WW_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             area1_dram,
    output logic [AREAS-1:0] rw_bits,
    output logic [REG_W-1:0] rdata
);
    localparam int RW_LSB = REG_W - AREAS;

    logic [AREAS-1:0] rw_q;
    logic             ww_q;

    // Register update: read-wait field free, write-wait bit guarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q <= '1;
            ww_q <= 1'b1;
        end else if (wr_en) begin
            rw_q <= wdata[REG_W-1:RW_LSB];
            if (wdata[WW_BIT] || area1_dram)
                ww_q <= wdata[WW_BIT];
        end
    end

    assign rw_bits = rw_q;

    // Read-back assembly, one bit at a time.
    for (genvar i = 0; i < REG_W; i++) begin : g_rd
        if (i >= RW_LSB) begin : g_rw
            assign rdata[i] = rw_q[i-RW_LSB];
        end else if (i == WW_BIT) begin : g_ww
            assign rdata[i] = ww_q;
        end else begin : g_fix
            assign rdata[i] = 1'b1;
        end
    end
endmodule

// File: rtl/rwg_rule.sv
`timescale 1ns/1ps
// Module: timing rule selection.
// Maps area, space type, the area's read-wait bit and the long-wait value
// onto a fixed wait count and a flag for sampling wait_n. Purely combinational.
module rwg_rule
    import rwg_pkg::*;
#(
    parameter int              AREAS     = 8,
    parameter int              LONG_W    = 2,
    parameter logic [AREAS-1:0] LONG_MASK = 8'b0100_0101
) (
    input  logic [$clog2(AREAS)-1:0] area,
    input  logic [2:0]               space,
    input  logic [AREAS-1:0]         rw_bits,
    input  logic [LONG_W-1:0]        long_wait,
    output timing_t                  timing
);
    localparam logic [CNT_W-1:0] W_NONE   = CNT_W'(0);
    localparam logic [CNT_W-1:0] W_STD    = CNT_W'(2);
    localparam logic [CNT_W-1:0] W_PERIPH = CNT_W'(2);
    localparam logic [CNT_W-1:0] W_MUX    = CNT_W'(4);

    logic rw_bit;
    logic long_area;

    assign rw_bit    = rw_bits[area];
    assign long_area = LONG_MASK[area];

    // Rule table per space type.
    always_comb begin
        timing.waits  = W_NONE;
        timing.sample = 1'b0;
        case (space_e'(space))
            SPC_EXT: begin
                if (long_area) begin
                    timing.waits  = CNT_W'(long_wait);
                    timing.sample = rw_bit;
                end else begin
                    timing.waits  = rw_bit ? W_STD : W_NONE;
                    timing.sample = rw_bit;
                end
            end
            SPC_DRAM: begin
                timing.waits  = rw_bit ? W_STD : W_NONE;
                timing.sample = rw_bit;
            end
            SPC_MUXIO: begin
                timing.waits  = W_MUX;
                timing.sample = 1'b1;
            end
            SPC_ONCHIP_PERIPH: begin
                timing.waits  = W_PERIPH;
                timing.sample = 1'b0;
            end
            default: begin
                timing.waits  = W_NONE;
                timing.sample = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rwg_counter.sv
`timescale 1ns/1ps
// Module: access cycle counter.
// Accepts a start while idle, counts the fixed wait cycles, then holds on
// each low wait_n sample if sampling is enabled. Pulses ready for one cycle.
module rwg_counter
    import rwg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t timing,
    input  logic    wait_n,
    output logic    busy,
    output logic    ready
);
    logic [CNT_W-1:0] rem_q;
    logic             samp_q;

    // Access sequencing: accept, count down, stretch, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            ready  <= 1'b0;
            rem_q  <= '0;
            samp_q <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (!busy && start) begin
                samp_q <= timing.sample;
                if (timing.waits == '0) begin
                    if (timing.sample && !wait_n) begin
                        busy  <= 1'b1;
                        rem_q <= CNT_W'(1);
                    end else begin
                        ready <= 1'b1;
                    end
                end else begin
                    busy  <= 1'b1;
                    rem_q <= timing.waits;
                end
            end else if (busy) begin
                if (rem_q > CNT_W'(1)) begin
                    rem_q <= rem_q - CNT_W'(1);
                end else if (!(samp_q && !wait_n)) begin
                    busy  <= 1'b0;
                    ready <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rd_wait_gen.sv
`timescale 1ns/1ps
// Module: per-area read wait-state generator (top).
// Joins the configuration word, the rule table and the cycle counter.
// Assumes rd_area, rd_space and long_wait are valid in the rd_req cycle.
module rd_wait_gen
    import rwg_pkg::*;
#(
    parameter int              AREAS     = 8,
    parameter int              REG_W     = 16,
    parameter int              LONG_W    = 2,
    parameter logic [AREAS-1:0] LONG_MASK = 8'b0100_0101
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    input  logic                     area1_dram,
    input  logic                     rd_req,
    input  logic [$clog2(AREAS)-1:0] rd_area,
    input  logic [2:0]               rd_space,
    input  logic [LONG_W-1:0]        long_wait,
    input  logic                     wait_n,
    output logic                     busy,
    output logic                     ready
);
    logic [AREAS-1:0] rw_bits;
    timing_t          timing;

    rwg_ctrl_reg #(.AREAS(AREAS), .REG_W(REG_W), .WW_BIT(1)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wdata      (cfg_wdata),
        .area1_dram (area1_dram),
        .rw_bits    (rw_bits),
        .rdata      (cfg_rdata)
    );

    rwg_rule #(.AREAS(AREAS), .LONG_W(LONG_W), .LONG_MASK(LONG_MASK)) u_rule (
        .area      (rd_area),
        .space     (rd_space),
        .rw_bits   (rw_bits),
        .long_wait (long_wait),
        .timing    (timing)
    );

    rwg_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (rd_req),
        .timing (timing),
        .wait_n (wait_n),
        .busy   (busy),
        .ready  (ready)
    );
endmodule

// File: rtl/rwg_checker.sv
`timescale 1ns/1ps
// Module: property checker for rd_wait_gen, attached by bind.
// Watches ports only; treats the read-back word as the source of the area bits.
module rwg_checker #(
    parameter logic [7:0] LONG_MASK = 8'b0100_0101
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        area1_dram,
    input logic        rd_req,
    input logic [2:0]  rd_area,
    input logic [2:0]  rd_space,
    input logic        busy,
    input logic        ready
);
    logic start;
    assign start = rd_req && !busy;

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !busy); // R11

    AST_SHORT_EXT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_space == 3'd0 && !LONG_MASK[rd_area] && !cfg_rdata[8 + rd_area])
        |=> ready); // R2

    AST_ONCHIP_MEM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_space == 3'd3) |=> ready); // R8

    AST_PERIPH_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_space == 3'd4) |=> busy ##1 busy ##1 ready); // R8

    AST_MUXIO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_space == 3'd2) |=> busy ##3 busy); // R7

    AST_WW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_wdata[1] && !area1_dram && cfg_rdata[1]) |=> cfg_rdata[1]); // R9
endmodule

bind rd_wait_gen rwg_checker #(.LONG_MASK(8'b0100_0101)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .area1_dram (area1_dram),
    .rd_req     (rd_req),
    .rd_area    (rd_area),
    .rd_space   (rd_space),
    .busy       (busy),
    .ready      (ready)
);

// File: tb/test_rd_wait_gen.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_rd_wait_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        area1_dram = 1'b0;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_area = '0;
    logic [2:0]  rd_space = '0;
    logic [1:0]  long_wait = '0;
    logic        wait_n = 1'b1;
    logic        busy;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rd_wait_gen i_rd_wait_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .area1_dram(area1_dram), .rd_req(rd_req),
        .rd_area(rd_area), .rd_space(rd_space), .long_wait(long_wait),
        .wait_n(wait_n), .busy(busy), .ready(ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] d, input logic dram1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d; area1_dram = dram1;
        @(negedge clk);
        cfg_wr = 1'b0; area1_dram = 1'b0;
    endtask

    // One read; wait_n is low for the first lowlen sampling edges.
    task automatic access(input int ar, input int sp, input int lw,
                          input int lowlen, input int exp_t, input string tag);
        int t = 0;
        @(negedge clk);
        rd_area = 3'(ar); rd_space = 3'(sp); long_wait = 2'(lw);
        rd_req = 1'b1; wait_n = (lowlen >= 1) ? 1'b0 : 1'b1;
        for (int k = 1; k <= 40 && t == 0; k++) begin
            @(negedge clk);
            rd_req = 1'b0;
            wait_n = (k + 1 <= lowlen) ? 1'b0 : 1'b1;
            if (ready) t = k;
        end
        wait_n = 1'b1;
        check(tag, t, exp_t);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rdata", int'(cfg_rdata), 16'hFFFF);
        check("R1 ready", int'(ready), 0);
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_register();
        cfg_write(16'h0000, 1'b0);
        check("R9 guarded bit kept / R10 fixed ones", int'(cfg_rdata), 16'h00FF);
        cfg_write(16'h0000, 1'b1);
        check("R9 bit1 cleared with area1_dram", int'(cfg_rdata), 16'h00FD);
        cfg_write(16'hA500, 1'b1);
        check("R10 field written, fixed bits ones", int'(cfg_rdata), 16'hA5FD);
        cfg_write(16'hFFFF, 1'b0);
        check("R9 bit1 set back without area1_dram", int'(cfg_rdata), 16'hFFFF);
    endtask

    task automatic t_ext_short_group();
        cfg_write(16'h0000, 1'b0);
        access(3, 0, 3, 6, 1, "R2 area3 bit0 wait_n low ignored");
        access(7, 0, 0, 0, 1, "R2 area7 bit0");
        cfg_write(16'hFF00, 1'b0);
        access(3, 0, 0, 0, 3, "R3 area3 bit1 no stretch");
        access(5, 0, 3, 4, 5, "R3 area5 bit1 two low samples, long_wait ignored R12");
    endtask

    task automatic t_ext_long_group();
        cfg_write(16'h0000, 1'b0);
        access(0, 0, 2, 8, 3, "R4 area0 bit0 long2 wait_n ignored");
        access(6, 0, 0, 8, 1, "R4 area6 bit0 long0");
        cfg_write(16'hFF00, 1'b0);
        access(2, 0, 0, 2, 3, "R5 area2 bit1 long0 stretch2");
        access(6, 0, 3, 4, 5, "R5 area6 bit1 long3 stretch1");
        access(0, 0, 1, 0, 2, "R5 area0 bit1 long1 no stretch");
    endtask

    task automatic t_dram();
        cfg_write(16'h0000, 1'b0);
        access(1, 1, 3, 6, 1, "R6 dram bit0 short pitch, R12 long ignored");
        cfg_write(16'hFF00, 1'b0);
        access(1, 1, 0, 3, 4, "R6 dram bit1 long pitch stretch1");
    endtask

    task automatic t_muxio();
        cfg_write(16'h0000, 1'b0);
        access(4, 2, 0, 4, 5, "R7 muxio bits0 no stretch");
        cfg_write(16'hFF00, 1'b0);
        access(2, 2, 3, 7, 8, "R7 muxio stretch3, R12 long ignored");
    endtask

    task automatic t_onchip();
        access(0, 3, 3, 8, 1, "R8 onchip mem wait_n ignored");
        access(2, 4, 3, 8, 3, "R8 onchip periph wait_n ignored");
    endtask

    task automatic t_busy_ignore();
        int pulses = 0;
        int first = 0;
        @(negedge clk);
        rd_area = 3'd0; rd_space = 3'd4; long_wait = 2'd0; rd_req = 1'b1; wait_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            rd_req = (k == 1);
            rd_space = (k == 1) ? 3'd3 : 3'd4;
            if (ready) begin
                pulses++;
                if (first == 0) first = k;
            end
        end
        rd_req = 1'b0;
        check("R11 single ready pulse", pulses, 1);
        check("R11 ready at cycle 3", first, 3);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_register();
        t_ext_short_group();
        t_ext_long_group();
        t_dram();
        t_muxio();
        t_onchip();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule